// File: doc/BRIEF.md
# Configuration Memory Data Streamer

This block reads a stored configuration image out of an on-chip memory array and presents it, word by word or bit by bit, to a downstream programmable-logic device that is loading its configuration. The memory holds several independent images ("revisions") of equal size, laid out back to back. At the start of each read sequence the block picks one revision, either from two select pins (when the pin-select enable is high) or from a revision number strapped by a parameter. It then walks that revision from its first word to its last.

Two output formats are offered. In parallel mode a full 8-bit word is driven on all eight data lanes each cycle, and the downstream device can stall the stream with a busy input. In serial mode only lane 0 is driven, one bit per clock, most significant bit first. Streaming runs only while the device is selected, the drive-enable/reset input is high and the load request is high. When the last word has gone out, the block releases its data lanes and pulls a cascade select low, so that the next memory in a chain can carry on the stream. While the memory is being reprogrammed, the block freezes, keeps its lanes released and holds the cascade select high.

The memory array is outside the block. The array is read through a synchronous port: the address driven in one cycle returns its data after the next rising edge.

Top module: `cfg_stream`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), all eight lane enables `dq_oe` are 0 and `next_sel_n` is 1.
- R2: Lane enables are 0 unless the block is streaming, `dev_sel_n` is 0, `drive_en_rst_n` is 1, `load_req` is 1 and `prog_mode` is 0.
- R3: In parallel mode (`par_mode`=1 at start), `dq_oe`=8'hFF, and each rising edge with `sink_busy` low advances `dq_o` to the next word of the revision, starting at its first word.
- R4: In parallel mode, a rising edge with `sink_busy` high leaves the presented word unchanged.
- R5: In serial mode (`par_mode`=0 at start), `dq_oe`=8'h01 and `dq_o[0]` carries one bit per rising edge, bit 7 of each word first and bit 0 last, before the next word begins.
- R6: At start, the revision is `pin_rev` when `pin_sel_en` is 1 and `BOOT_REV` otherwise. Revision r occupies memory addresses r*REV_WORDS to r*REV_WORDS+REV_WORDS-1.
- R7: The revision and mode are captured only when a read sequence starts. Changes to `pin_rev`, `pin_sel_en` or `par_mode` during a stream have no effect on it.
- R8: A rising edge with `drive_en_rst_n` low (outside programming) returns the block to idle with its offset at 0. The next start presents word 0 of the revision selected at that start.
- R9: After the last word (parallel) or its last bit (serial) has been consumed, `next_sel_n` goes to 0 and `dq_oe` to 0. They stay there until R8 restarts the block.
- R10: While `prog_mode` is 1, `next_sel_n` is 1 and `dq_oe` is 0, and every other control input is ignored. When `prog_mode` drops, streaming resumes at the same word.
- R11: A rising edge during a stream with `load_req` low or `dev_sel_n` high releases the lanes and does not advance the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel_n | input | 1 | Device select, active low |
| drive_en_rst_n | input | 1 | High enables output; low restarts the sequence |
| load_req | input | 1 | Configuration load request, high to stream |
| sink_busy | input | 1 | Downstream stall request (parallel mode) |
| par_mode | input | 1 | 1 = eight lanes per word, 0 = one lane per bit |
| pin_sel_en | input | 1 | 1 = revision from `pin_rev` |
| pin_rev | input | REV_W | Revision number from pins |
| prog_mode | input | 1 | Memory is being reprogrammed |
| mem_addr | output | ADDR_W | Read address to the memory array |
| mem_rdata | input | WORD_W | Read data, one cycle after the address |
| dq_o | output | WORD_W | Data lane values |
| dq_oe | output | WORD_W | Per-lane drive enable (0 = high impedance) |
| next_sel_n | output | 1 | Select for the next device in the chain, active low |

## Verification
The hardest situation to reach is programming mode arriving in the middle of a stream while the other inputs change. The block must then hold its word, ignore a restart pulse, a stall and a new revision, and resume at the same word once programming ends. The bench stops a parallel stream at its second word and raises `prog_mode`. While `prog_mode` is high, it drops `drive_en_rst_n`, asserts `sink_busy` and changes `pin_rev`. It then releases everything and checks the word shown at once and the one after the next edge. The same input is also raised after the end of the image, to show that it overrides the low cascade select.

// File: rtl/cfgs_pkg.sv
// Package: shared types for the configuration data streamer.
package cfgs_pkg;
    // Sequencer states: waiting for a start, streaming, image exhausted.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } strm_state_e;
endpackage

// File: rtl/cfgs_rev_select.sv
// Revision selector. Chooses the revision from pins or from a strapped
// default and captures it when a read sequence starts.
// Assumes: start is a single-cycle pulse from the sequencer.
module cfgs_rev_select #(
    parameter int REV_W    = 2,
    parameter int BOOT_REV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_sel_en,
    input  logic [REV_W-1:0] pin_rev,
    input  logic             start,
    output logic [REV_W-1:0] sel_now,
    output logic [REV_W-1:0] rev_q
);
    localparam logic [REV_W-1:0] BOOT_V = REV_W'(BOOT_REV);

    // Pick the candidate revision from pins or the strap.
    always_comb begin
        sel_now = pin_sel_en ? pin_rev : BOOT_V;
    end

    // Capture the revision only at the start of a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_q <= BOOT_V;
        end else if (start) begin
            rev_q <= sel_now;
        end
    end

    // R7: the captured revision never moves mid-stream.
    p_rev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(rev_q));
    // R6: the pins win when their enable is high at start.
    p_rev_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pin_sel_en) |=> rev_q == $past(pin_rev));
endmodule

// File: rtl/cfgs_stream_fsm.sv
// Stream sequencer. Tracks the word offset and the bit position inside the
// selected revision, and computes the offset the memory must read so that
// its registered output holds the presented word after each edge.
// Assumes: REV_WORDS and WORD_W are powers of two.
module cfgs_stream_fsm
    import cfgs_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int REV_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_sel_n,
    input  logic              drive_en_rst_n,
    input  logic              load_req,
    input  logic              sink_busy,
    input  logic              par_mode,
    input  logic              prog_mode,
    output strm_state_e       state_q,
    output logic              start,
    output logic              show,
    output logic              mode_q,
    output logic [$clog2(WORD_W)-1:0]    bit_q,
    output logic [$clog2(REV_WORDS)-1:0] fetch_off
);
    localparam int OFF_W = $clog2(REV_WORDS);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(REV_WORDS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    logic [OFF_W-1:0] ptr_q;
    logic             live;
    logic             adv;
    logic             last_word;
    logic             last_bit;

    // Decode start, presentation, advance and next fetch offset.
    always_comb begin
        live      = !dev_sel_n && drive_en_rst_n && load_req && !prog_mode;
        start     = (state_q == ST_IDLE) && live;
        show      = (state_q == ST_RUN) && live;
        last_bit  = (bit_q == BIT_LAST);
        last_word = (ptr_q == OFF_LAST);
        adv       = show && (mode_q ? !sink_busy : last_bit);
        fetch_off = (adv && !last_word) ? ptr_q + 1'b1 : ptr_q;
    end

    // Sequencer registers; frozen while the memory is being programmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            bit_q   <= '0;
            mode_q  <= 1'b0;
        end else if (!prog_mode) begin
            if (!drive_en_rst_n) begin
                state_q <= ST_IDLE;
                ptr_q   <= '0;
                bit_q   <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            state_q <= ST_RUN;
                            mode_q  <= par_mode;
                            ptr_q   <= '0;
                            bit_q   <= '0;
                        end
                    end
                    ST_RUN: begin
                        if (adv) begin
                            bit_q <= '0;
                            if (last_word) begin
                                state_q <= ST_DONE;
                            end else begin
                                ptr_q <= ptr_q + 1'b1;
                            end
                        end else if (show && !mode_q) begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= ST_DONE;
                    end
                endcase
            end
        end
    end

    // R4: a stall in parallel mode keeps the word in place.
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (show && mode_q && sink_busy) |=> ($stable(ptr_q) && state_q == ST_RUN));
    // R10: programming freezes the whole sequencer.
    p_prog_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode |=> ($stable(ptr_q) && $stable(state_q) && $stable(bit_q)));
    // R8: a low drive-enable returns to offset 0 in idle.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_mode && !drive_en_rst_n) |=> (state_q == ST_IDLE && ptr_q == '0));
    // R9: consuming the last word ends the image.
    p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last_word) |=> state_q == ST_DONE);
    // R11: a paused stream does not advance.
    p_pause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !show && drive_en_rst_n) |=> $stable(ptr_q));
    // R5: serial mode steps one bit per presented cycle.
    p_serial_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (show && !mode_q && !last_bit) |=> bit_q == $past(bit_q) + 1'b1);
endmodule

// File: rtl/cfgs_out_drive.sv
// Lane driver. Maps the memory word onto the data lanes in the captured
// mode and drives the cascade select.
// Assumes: mem_rdata holds the word the sequencer is presenting.
module cfgs_out_drive #(
    parameter int WORD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      show,
    input  logic                      mode_q,
    input  logic                      done,
    input  logic                      prog_mode,
    input  logic [$clog2(WORD_W)-1:0] bit_q,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic [WORD_W-1:0]         dq_o,
    output logic [WORD_W-1:0]         dq_oe,
    output logic                      next_sel_n
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    logic serial_bit;

    // Select the serial bit, most significant first.
    always_comb begin
        serial_bit = mem_rdata[TOP_BIT - bit_q];
    end

    // Lane 0 carries either the serial bit or word bit 0.
    always_comb begin
        dq_o[0]  = show ? (mode_q ? mem_rdata[0] : serial_bit) : 1'b0;
        dq_oe[0] = show;
    end

    // Upper lanes are driven only in parallel mode.
    for (genvar ln = 1; ln < WORD_W; ln++) begin : g_lane
        always_comb begin
            dq_o[ln]  = (show && mode_q) ? mem_rdata[ln] : 1'b0;
            dq_oe[ln] = show && mode_q;
        end
    end

    // Cascade select drops at end of image unless programming.
    always_comb begin
        next_sel_n = !(done && !prog_mode);
    end

    // R10: programming holds the cascade select high and lanes off.
    p_cascade_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode |-> (next_sel_n && dq_oe == '0));
    // R2: no presentation means released lanes.
    p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !show |-> dq_oe == '0);
    // R9: end of image releases lanes and hands on.
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !prog_mode) |-> (!next_sel_n && dq_oe == '0));
    // R5: serial mode drives at most lane 0.
    p_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (show && !mode_q) |-> $onehot0(dq_oe) && dq_oe[0]);
endmodule

// File: rtl/cfg_stream.sv
// Configuration memory data streamer, top level. Selects a revision,
// sequences reads through it and drives the data lanes in serial or
// parallel form, then hands on to the next device in a chain.
// Assumes: synchronous memory with one cycle read latency; revisions of
// REV_WORDS words placed back to back; REV_WORDS a power of two.
module cfg_stream
    import cfgs_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int REV_CNT   = 4,
    parameter int REV_WORDS = 16,
    parameter int BOOT_REV  = 1,
    parameter int REV_W     = $clog2(REV_CNT),
    parameter int ADDR_W    = $clog2(REV_CNT) + $clog2(REV_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_sel_n,
    input  logic              drive_en_rst_n,
    input  logic              load_req,
    input  logic              sink_busy,
    input  logic              par_mode,
    input  logic              pin_sel_en,
    input  logic [REV_W-1:0]  pin_rev,
    input  logic              prog_mode,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] dq_o,
    output logic [WORD_W-1:0] dq_oe,
    output logic              next_sel_n
);
    localparam int OFF_W = $clog2(REV_WORDS);
    localparam int BIT_W = $clog2(WORD_W);

    strm_state_e      state_q;
    logic             start;
    logic             show;
    logic             mode_q;
    logic [BIT_W-1:0] bit_q;
    logic [OFF_W-1:0] fetch_off;
    logic [REV_W-1:0] sel_now;
    logic [REV_W-1:0] rev_q;
    logic [REV_W-1:0] addr_rev;
    logic             done;

    cfgs_rev_select #(.REV_W(REV_W), .BOOT_REV(BOOT_REV)) u_rev (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sel_en (pin_sel_en),
        .pin_rev    (pin_rev),
        .start      (start),
        .sel_now    (sel_now),
        .rev_q      (rev_q)
    );

    cfgs_stream_fsm #(.WORD_W(WORD_W), .REV_WORDS(REV_WORDS)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .dev_sel_n      (dev_sel_n),
        .drive_en_rst_n (drive_en_rst_n),
        .load_req       (load_req),
        .sink_busy      (sink_busy),
        .par_mode       (par_mode),
        .prog_mode      (prog_mode),
        .state_q        (state_q),
        .start          (start),
        .show           (show),
        .mode_q         (mode_q),
        .bit_q          (bit_q),
        .fetch_off      (fetch_off)
    );

    // Form the memory address from revision base and fetch offset.
    always_comb begin
        addr_rev = (state_q == ST_IDLE) ? sel_now : rev_q;
        mem_addr = {addr_rev, fetch_off};
        done     = (state_q == ST_DONE);
    end

    cfgs_out_drive #(.WORD_W(WORD_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .show       (show),
        .mode_q     (mode_q),
        .done       (done),
        .prog_mode  (prog_mode),
        .bit_q      (bit_q),
        .mem_rdata  (mem_rdata),
        .dq_o       (dq_o),
        .dq_oe      (dq_oe),
        .next_sel_n (next_sel_n)
    );

    // R1: the cycle after reset shows released lanes and a high cascade select.
    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (dq_oe == '0 && next_sel_n));
endmodule

// File: tb/sim_cfg_stream.sv
`timescale 1ns/1ps
// Directed bench for cfg_stream with a synchronous memory model.
module sim_cfg_stream;
    localparam int RW = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_sel_n = 1'b1;
    logic       drive_en_rst_n = 1'b0;
    logic       load_req = 1'b0;
    logic       sink_busy = 1'b0;
    logic       par_mode = 1'b0;
    logic       pin_sel_en = 1'b0;
    logic [1:0] pin_rev = 2'd0;
    logic       prog_mode = 1'b0;
    logic [5:0] mem_addr;
    logic [7:0] mem_rdata = 8'd0;
    logic [7:0] dq_o;
    logic [7:0] dq_oe;
    logic       next_sel_n;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    cfg_stream u0 (
        .clk(clk), .rst_n(rst_n), .dev_sel_n(dev_sel_n),
        .drive_en_rst_n(drive_en_rst_n), .load_req(load_req),
        .sink_busy(sink_busy), .par_mode(par_mode), .pin_sel_en(pin_sel_en),
        .pin_rev(pin_rev), .prog_mode(prog_mode), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dq_o(dq_o), .dq_oe(dq_oe),
        .next_sel_n(next_sel_n)
    );

    function automatic logic [7:0] wv(int a);
        return 8'(a * 37 + 11);
    endfunction

    // Memory model: one-cycle synchronous read.
    always @(posedge clk) mem_rdata <= wv(int'(mem_addr));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic go(logic par, logic sel_en, logic [1:0] rv);
        drive_en_rst_n = 1'b0;
        @(negedge clk);
        par_mode = par; pin_sel_en = sel_en; pin_rev = rv;
        drive_en_rst_n = 1'b1; load_req = 1'b1; dev_sel_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", dq_oe, 0);
        chk("R1 next_sel after reset", next_sel_n, 1);
        drive_en_rst_n = 1'b1; dev_sel_n = 1'b0;
        @(negedge clk);
        chk("R2 idle with load_req low", dq_oe, 0);
    endtask

    task automatic t_parallel();
        go(1'b1, 1'b1, 2'd2);
        for (int k = 0; k < RW; k++) begin
            chk("R3 parallel word", dq_o, wv(2 * RW + k));
            chk("R3 parallel lanes", dq_oe, 8'hFF);
            @(negedge clk);
        end
        chk("R9 next_sel at end", next_sel_n, 0);
        chk("R9 lanes off at end", dq_oe, 0);
        @(negedge clk);
        chk("R9 end held", next_sel_n, 0);
    endtask

    task automatic t_busy();
        go(1'b1, 1'b1, 2'd0);
        chk("R4 first word", dq_o, wv(0));
        @(negedge clk);
        chk("R4 second word", dq_o, wv(1));
        sink_busy = 1'b1;
        @(negedge clk);
        chk("R4 held word 1", dq_o, wv(1));
        @(negedge clk);
        chk("R4 held word 2", dq_o, wv(1));
        sink_busy = 1'b0;
        @(negedge clk);
        chk("R4 resumed", dq_o, wv(2));
    endtask

    task automatic t_serial();
        go(1'b0, 1'b0, 2'd3);
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 8; b++) begin
                logic [7:0] ev;
                ev = wv(RW + w);
                chk("R5 R6 serial bit", dq_o[0], ev[7 - b]);
                chk("R5 serial lane", dq_oe, 8'h01);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_rev_mid();
        go(1'b1, 1'b1, 2'd0);
        @(negedge clk);
        pin_rev = 2'd3; pin_sel_en = 1'b0; par_mode = 1'b0;
        @(negedge clk);
        chk("R7 revision kept", dq_o, wv(2));
        chk("R7 mode kept", dq_oe, 8'hFF);
    endtask

    task automatic t_restart();
        go(1'b1, 1'b1, 2'd2);
        repeat (3) @(negedge clk);
        chk("R3 word 3 before restart", dq_o, wv(2 * RW + 3));
        drive_en_rst_n = 1'b0;
        @(negedge clk);
        chk("R8 R2 lanes off in restart", dq_oe, 0);
        pin_rev = 2'd3; pin_sel_en = 1'b1; drive_en_rst_n = 1'b1;
        @(negedge clk);
        chk("R8 restart at word 0", dq_o, wv(3 * RW));
    endtask

    task automatic t_pause();
        go(1'b1, 1'b1, 2'd1);
        @(negedge clk);
        load_req = 1'b0;
        @(negedge clk);
        chk("R11 lanes off on load_req low", dq_oe, 0);
        load_req = 1'b1;
        #1;
        chk("R11 no advance on load_req low", dq_o, wv(RW + 1));
        @(negedge clk);
        chk("R11 continue", dq_o, wv(RW + 2));
        dev_sel_n = 1'b1;
        @(negedge clk);
        chk("R11 lanes off deselected", dq_oe, 0);
        dev_sel_n = 1'b0;
        #1;
        chk("R11 no advance deselected", dq_o, wv(RW + 2));
        @(negedge clk);
        chk("R11 continue after select", dq_o, wv(RW + 3));
    endtask

    task automatic t_prog();
        go(1'b1, 1'b1, 2'd2);
        @(negedge clk);
        prog_mode = 1'b1;
        @(negedge clk);
        chk("R10 next_sel high in prog", next_sel_n, 1);
        chk("R10 lanes off in prog", dq_oe, 0);
        drive_en_rst_n = 1'b0; pin_rev = 2'd0; sink_busy = 1'b1;
        @(negedge clk);
        drive_en_rst_n = 1'b1; sink_busy = 1'b0; prog_mode = 1'b0;
        #1;
        chk("R10 resume same word", dq_o, wv(2 * RW + 1));
        @(negedge clk);
        chk("R10 resume next word", dq_o, wv(2 * RW + 2));
        repeat (RW - 2) @(negedge clk);
        chk("R9 end reached", next_sel_n, 0);
        prog_mode = 1'b1;
        #1;
        chk("R10 prog overrides end", next_sel_n, 1);
        prog_mode = 1'b0;
        #1;
        chk("R9 end after prog", next_sel_n, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_parallel();
        t_busy();
        t_serial();
        t_rev_mid();
        t_restart();
        t_pause();
        t_prog();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule